// File: doc/BRIEF.md
# Streaming Display Memory Access Sequencer

This block stands between already-decoded host bus accesses and a single display memory port. The host opens a write stream with one command. Every data write that follows is taken into a small posted queue in the same cycle and tagged with the current cursor address. The queue then drains into memory whenever the memory grants. The host therefore keeps running at bus speed even when memory answers slowly. Overflow is reported through a sticky flag and never through a stall.

The host opens a read stream with another command. The block then fetches the word at the cursor into a one-word output buffer. Each host data read takes the buffered word and launches the fetch of the following address. A read that arrives while the buffer is still empty gets the old contents and sets a sticky underrun flag. A cursor-load command and any other non-data command close the current stream.

Top module: `dmem_stream_seq`

## Requirements
- R1: During and after reset, `mem_req`, `wr_overflow` and `rd_underrun` are 0, `rd_data` is 0, the cursor is 0 and no stream is open.
- R2: After a memory-write command (`cmd_op`=1), each host data write is stored at the cursor address and the cursor then steps by one. Memory receives these writes in host order.
- R3: The write queue takes one host write per cycle, back to back, up to `QDEPTH` entries with no grant. None of these writes is lost.
- R4: A host data write in write-stream mode while the queue is full is discarded, leaves the cursor unchanged and sets the sticky `wr_overflow` flag.
- R5: The memory port transfers only in a cycle with `mem_req` and `mem_gnt` both high. A pending write keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until it is granted.
- R6: A memory-read command (`cmd_op`=2) empties the buffer and requests a read at the cursor once all queued writes have drained. On grant it loads `mem_rdata` into the buffer and steps the cursor by one.
- R7: A host data read in read-stream mode with a full buffer returns the buffered word on `rd_data`, empties the buffer and requests the next word.
- R8: A host data read in read-stream mode with an empty buffer leaves `rd_data` at its old value, sets the sticky `rd_underrun` flag and issues no extra request. The fetch already pending still completes.
- R9: Any other command (`cmd_op`=0) closes the stream and withdraws a fetch that has not been granted. Later host reads change neither `rd_data` nor the memory port.
- R10: A cursor-load command (`cmd_op`=3) sets the cursor to `cmd_arg`, empties the buffer, withdraws an ungranted fetch and closes the stream.
- R11: Host data writes outside write-stream mode are ignored and cause no memory request.
- R12: When strobes coincide, a command takes precedence over a data write, and a data write over a data read. A command also discards a fetch that is granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 other, 1 memory write, 2 memory read, 3 load cursor |
| cmd_arg | input | ADDR_W | Cursor value for the load command |
| wr_valid | input | 1 | Host data write strobe |
| wr_data | input | DATA_W | Host write data |
| rd_valid | input | 1 | Host data read strobe |
| rd_data | output | DATA_W | Output buffer contents |
| wr_overflow | output | 1 | Sticky: a write was dropped on a full queue |
| rd_underrun | output | 1 | Sticky: a read found the buffer empty |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with grant |
| mem_gnt | input | 1 | Memory grant, completes the access this cycle |

## Verification
Every result is registered. A host strobe or grant seen at one rising edge shows up on the ports in the cycle after that edge. This covers the cursor, the buffer, the flags and the change in `mem_req` and `mem_addr`. The bench drives on the falling edge. A behavioural queue model advances on each rising edge, and the model's predictions are compared with every output on the next falling edge, so each result is checked in exactly the cycle it is due. Hand-computed checks after fixed idle gaps confirm memory contents, buffered words and flag states at the points where write drain, fetch completion, overflow and underrun are due.

// File: rtl/dseq_pkg.sv
// Shared types for the streaming display memory sequencer.
// Assumes a two-bit host command code supplied by an external decoder.
package dseq_pkg;
    typedef enum logic [1:0] {
        OP_OTHER  = 2'd0,
        OP_MWRITE = 2'd1,
        OP_MREAD  = 2'd2,
        OP_SETCUR = 2'd3
    } host_op_e;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,
        MODE_WSTREAM = 2'd1,
        MODE_RSTREAM = 2'd2
    } stream_mode_e;
endpackage

// File: rtl/post_queue.sv
// Posted-write queue: a circular buffer of address/data entries.
// Assumes the caller never pushes while full (the top gates push).
// DEPTH must be at least 2. Push and pop may happen in the same cycle.
module post_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign head  = slot_q[rd_ptr_q];

    // Store an incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_Q_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q < CNT_W'(DEPTH)));                                 // R4
    AST_Q_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));                                            // R5
endmodule

// File: rtl/mem_port_arb.sv
// Memory port selector: drains queued writes first, then issues the
// pending prefetch read. A transfer completes when req and gnt are both high.
// Assumes the queue head stays put until it is popped.
module mem_port_arb #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [DATA_W-1:0] q_data,
    input  logic              fetch_pend,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              mem_gnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wr_done,
    output logic              rd_done
);
    // Choose the access source: writes win over the fetch.
    always_comb begin
        mem_we    = !q_empty;
        mem_req   = !q_empty || fetch_pend;
        mem_addr  = mem_we ? q_addr : fetch_addr;
        mem_wdata = mem_we ? q_data : '0;
        wr_done   = mem_req && mem_gnt && mem_we;
        rd_done   = mem_req && mem_gnt && !mem_we;
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_gnt) |=>
        (mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata))); // R5
endmodule

// File: rtl/dmem_stream_seq.sv
// Streaming display memory sequencer top. It keeps the stream mode, the
// cursor, the one-word prefetch buffer and the sticky error flags.
// Assumes at most one meaningful host strobe per cycle. If several come
// together, command > write > read.
module dmem_stream_seq
    import dseq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_arg,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_overflow,
    output logic              rd_underrun,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_gnt
);
    localparam int ENT_W = ADDR_W + DATA_W;

    host_op_e          op;
    stream_mode_e      mode_q;
    logic [ADDR_W-1:0] cursor_q;
    logic [DATA_W-1:0] buf_q;
    logic              buf_vld_q, fetch_pend_q, ovf_q, und_q;
    logic              q_full, q_empty, wr_done, rd_done;
    logic [ENT_W-1:0]  q_head;
    logic              wr_take, push, rd_take;

    assign op      = host_op_e'(cmd_op);
    assign wr_take = !cmd_valid && wr_valid && (mode_q == MODE_WSTREAM);
    assign push    = wr_take && !q_full;
    assign rd_take = !cmd_valid && !wr_valid && rd_valid && (mode_q == MODE_RSTREAM);

    post_queue #(.DEPTH(QDEPTH), .W(ENT_W)) i_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({cursor_q, wr_data}),
        .pop       (wr_done),
        .full      (q_full),
        .empty     (q_empty),
        .head      (q_head)
    );

    mem_port_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_empty    (q_empty),
        .q_addr     (q_head[ENT_W-1:DATA_W]),
        .q_data     (q_head[DATA_W-1:0]),
        .fetch_pend (fetch_pend_q),
        .fetch_addr (cursor_q),
        .mem_gnt    (mem_gnt),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .wr_done    (wr_done),
        .rd_done    (rd_done)
    );

    // Stream mode follows the last command.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= MODE_IDLE;
        else if (cmd_valid) begin
            case (op)
                OP_MWRITE: mode_q <= MODE_WSTREAM;
                OP_MREAD:  mode_q <= MODE_RSTREAM;
                default:   mode_q <= MODE_IDLE;
            endcase
        end
    end

    // Cursor: loaded by command, stepped by each accepted write or finished fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cursor_q <= '0;
        else if (cmd_valid) begin
            if (op == OP_SETCUR)              cursor_q <= cmd_arg;
        end else if (rd_done || push)         cursor_q <= cursor_q + 1'b1;
    end

    // Prefetch buffer and fetch request state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q        <= '0;
            buf_vld_q    <= 1'b0;
            fetch_pend_q <= 1'b0;
        end else if (cmd_valid) begin
            fetch_pend_q <= (op == OP_MREAD);
            if (op == OP_MREAD || op == OP_SETCUR) buf_vld_q <= 1'b0;
        end else begin
            if (rd_done) begin
                buf_q        <= mem_rdata;
                buf_vld_q    <= 1'b1;
                fetch_pend_q <= 1'b0;
            end
            if (rd_take && buf_vld_q) begin
                buf_vld_q    <= 1'b0;
                fetch_pend_q <= 1'b1;
            end
        end
    end

    // Sticky overflow and underrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            und_q <= 1'b0;
        end else begin
            if (wr_take && q_full)    ovf_q <= 1'b1;
            if (rd_take && !buf_vld_q) und_q <= 1'b1;
        end
    end

    assign rd_data     = buf_q;
    assign wr_overflow = ovf_q;
    assign rd_underrun = und_q;

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_overflow) |-> ($past(wr_valid) && $past(mode_q == MODE_WSTREAM))); // R4
    AST_UND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_underrun) |-> ($past(rd_valid) && $past(mode_q == MODE_RSTREAM))); // R8
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !cmd_valid) |=> (cursor_q == ADDR_W'($past(cursor_q) + 1'b1)));  // R6
    AST_SETCUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SETCUR) |=> (cursor_q == $past(cmd_arg) && !buf_vld_q && !mem_req) or !$past(q_empty) or !q_empty); // R10
    AST_BUF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_vld_q && fetch_pend_q));                                     // R7
endmodule

// File: tb/test_dmem_stream_seq.sv
module test_dmem_stream_seq;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int QD     = 4;
    localparam int MSIZE  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, wr_valid = 1'b0, rd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [ADDR_W-1:0] cmd_arg = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data, mem_wdata, mem_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic wr_overflow, rd_underrun, mem_req, mem_we, mem_gnt;

    int gnt_mode = 0;  // 0 never, 1 always, 2 pseudo-random
    logic [15:0] lfsr = 16'hACE1;
    int checks = 0, errors = 0, cycles = 0;
    string ph = "R1";

    logic [DATA_W-1:0] mem_arr [MSIZE];
    logic s_req, s_we;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_wdata;

    // reference model state
    logic [ADDR_W+DATA_W-1:0] m_q [$];
    int m_mode;  // 0 idle, 1 write stream, 2 read stream
    logic [ADDR_W-1:0] m_cur;
    logic [DATA_W-1:0] m_buf;
    logic m_vld, m_pend, m_ovf, m_und, model_ok = 1'b0;

    always #4 clk = ~clk;

    assign mem_gnt   = (gnt_mode == 1) || (gnt_mode == 2 && lfsr[0]);
    assign mem_rdata = mem_arr[mem_addr];

    dmem_stream_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .QDEPTH(QD)) i_dmem_stream_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_overflow(wr_overflow),
        .rd_underrun(rd_underrun), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < MSIZE; i++) mem_arr[i] = DATA_W'(i) ^ 8'h5A;
    end

    // Model step, memory write and watchdog on the rising edge.
    always @(posedge clk) begin
        logic xfer, we, vpre, fullpre;
        logic [DATA_W-1:0] rword;
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (s_req && s_we && mem_gnt) mem_arr[s_addr] <= s_wdata;
        if (!rst_n) begin
            m_q.delete();
            m_mode = 0; m_cur = '0; m_buf = '0;
            m_vld = 0; m_pend = 0; m_ovf = 0; m_und = 0;
            model_ok = 1'b1;
        end else begin
            we      = (m_q.size() != 0);
            xfer    = (we || m_pend) && mem_gnt;
            vpre    = m_vld;
            fullpre = (m_q.size() == QD);
            rword   = mem_arr[m_cur];
            if (xfer && we) void'(m_q.pop_front());
            if (cmd_valid) begin
                m_pend = (cmd_op == 2'd2);
                if (cmd_op == 2'd2 || cmd_op == 2'd3) m_vld = 0;
                if (cmd_op == 2'd3) m_cur = cmd_arg;
                m_mode = (cmd_op == 2'd1) ? 1 : (cmd_op == 2'd2) ? 2 : 0;
            end else begin
                if (xfer && !we) begin
                    m_buf = rword; m_vld = 1; m_pend = 0; m_cur = m_cur + 1'b1;
                end
                if (wr_valid) begin
                    if (m_mode == 1) begin
                        if (fullpre) m_ovf = 1;
                        else begin
                            m_q.push_back({m_cur, wr_data});
                            m_cur = m_cur + 1'b1;
                        end
                    end
                end else if (rd_valid && m_mode == 2) begin
                    if (vpre) begin m_vld = 0; m_pend = 1; end
                    else m_und = 1;
                end
            end
        end
    end

    // Compare every output against the model on the falling edge.
    always @(negedge clk) begin
        logic e_req, e_we;
        logic [ADDR_W+DATA_W-1:0] hd;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        s_req = mem_req; s_we = mem_we; s_addr = mem_addr; s_wdata = mem_wdata;
        if (model_ok && rst_n) begin
            e_we  = (m_q.size() != 0);
            e_req = e_we || m_pend;
            hd    = e_we ? m_q[0] : '0;
            chk({ph, "/R5"}, "mem_req", 32'(mem_req), 32'(e_req));
            if (e_req) begin
                chk({ph, "/R5"}, "mem_we", 32'(mem_we), 32'(e_we));
                chk({ph, "/R5"}, "mem_addr", 32'(mem_addr),
                    e_we ? 32'(hd[ADDR_W+DATA_W-1:DATA_W]) : 32'(m_cur));
                if (e_we) chk({ph, "/R5"}, "mem_wdata", 32'(mem_wdata), 32'(hd[DATA_W-1:0]));
            end
            chk(ph, "rd_data", 32'(rd_data), 32'(m_buf));
            chk(ph, "wr_overflow", 32'(wr_overflow), 32'(m_ovf));
            chk(ph, "rd_underrun", 32'(rd_underrun), 32'(m_und));
        end
    end

    task automatic host(input logic cv, input logic [1:0] op, input logic [7:0] arg,
                        input logic wv, input logic [7:0] wd, input logic rv);
        cmd_valid = cv; cmd_op = op; cmd_arg = arg;
        wr_valid = wv; wr_data = wd; rd_valid = rv;
        @(negedge clk);
        cmd_valid = 0; wr_valid = 0; rd_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "mem_req", 32'(mem_req), 0);
        chk("R1", "rd_data", 32'(rd_data), 0);
        chk("R1", "wr_overflow", 32'(wr_overflow), 0);
        chk("R1", "rd_underrun", 32'(rd_underrun), 0);

        // R2: write stream at 0x20, random grant
        ph = "R2"; gnt_mode = 2;
        host(1, 2'd3, 8'h20, 0, 0, 0);
        host(1, 2'd1, 0, 0, 0, 0);
        host(0, 0, 0, 1, 8'hA1, 0);
        host(0, 0, 0, 1, 8'hA2, 0);
        host(0, 0, 0, 1, 8'hA3, 0);
        idle(12);
        chk("R2", "mem[20]", 32'(mem_arr[8'h20]), 32'hA1);
        chk("R2", "mem[21]", 32'(mem_arr[8'h21]), 32'hA2);
        chk("R2", "mem[22]", 32'(mem_arr[8'h22]), 32'hA3);

        // R3 and R4: burst with no grant
        ph = "R3"; gnt_mode = 0;
        host(1, 2'd1, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) host(0, 0, 0, 1, 8'hB0 + 8'(i), 0);
        chk("R3", "wr_overflow", 32'(wr_overflow), 0);
        chk("R5", "mem_addr held", 32'(mem_addr), 32'h23);
        ph = "R4";
        host(0, 0, 0, 1, 8'hB4, 0);
        host(0, 0, 0, 1, 8'hB5, 0);
        chk("R4", "wr_overflow", 32'(wr_overflow), 1);
        gnt_mode = 1; idle(8);
        chk("R4", "mem[26]", 32'(mem_arr[8'h26]), 32'hB3);
        chk("R4", "mem[27] untouched", 32'(mem_arr[8'h27]), 32'h27 ^ 32'h5A);

        // R6 and R7: prefetch stream from 0x20
        ph = "R6"; gnt_mode = 2;
        host(1, 2'd3, 8'h20, 0, 0, 0);
        host(1, 2'd2, 0, 0, 0, 0);
        idle(12);
        chk("R6", "rd_data", 32'(rd_data), 32'hA1);
        ph = "R7";
        host(0, 0, 0, 0, 0, 1);
        idle(12);
        chk("R7", "rd_data", 32'(rd_data), 32'hA2);
        host(0, 0, 0, 0, 0, 1);
        idle(12);
        chk("R7", "rd_data", 32'(rd_data), 32'hA3);

        // R8: underrun
        ph = "R8"; gnt_mode = 0;
        host(0, 0, 0, 0, 0, 1);
        host(0, 0, 0, 0, 0, 1);
        chk("R8", "rd_underrun", 32'(rd_underrun), 1);
        chk("R8", "rd_data", 32'(rd_data), 32'hA3);
        gnt_mode = 1; idle(3);
        chk("R8", "rd_data late", 32'(rd_data), 32'hB0);

        // R9 and R11: stream closed, strobes ignored
        ph = "R9";
        host(1, 2'd0, 0, 0, 0, 0);
        host(0, 0, 0, 0, 0, 1);
        chk("R9", "mem_req", 32'(mem_req), 0);
        chk("R9", "rd_data", 32'(rd_data), 32'hB0);
        ph = "R11";
        host(0, 0, 0, 1, 8'hEE, 0);
        chk("R11", "mem_req", 32'(mem_req), 0);

        // R10: cursor load cancels a pending fetch
        ph = "R10"; gnt_mode = 0;
        host(1, 2'd3, 8'h40, 0, 0, 0);
        host(1, 2'd2, 0, 0, 0, 0);
        chk("R6", "mem_addr", 32'(mem_addr), 32'h40);
        host(1, 2'd3, 8'h50, 0, 0, 0);
        chk("R10", "mem_req", 32'(mem_req), 0);
        gnt_mode = 1;
        host(1, 2'd2, 0, 0, 0, 0);
        idle(2);
        chk("R10", "rd_data", 32'(rd_data), 32'h50 ^ 32'h5A);

        // R12: random mixed strobes checked by the model
        ph = "R12"; gnt_mode = 2;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            host(r[3:0] == 0, r[5:4], {4'h3, r[11:8]}, r[13:12] != 0,
                 r[23:16], r[15:14] != 0);
        end
        idle(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule